// File: doc/BRIEF.md
# Successive-Approximation Register Controller

This block is the digital half of a successive-approximation converter. A start pulse begins a conversion. The block then settles one bit per clock, from the most significant bit down to the least. In each cycle it drives a trial code to an external DAC and reads one comparator bit. That bit reports whether the sampled input lies above the DAC level. The trial bit is kept when the comparator is high and cleared when it is low.

Every conversion takes the same number of cycles, whatever the input level. The finished code appears on a parallel output together with a single-cycle done strobe. Each decided bit is also presented serially, most significant first, with a valid qualifier. A consumer of the serial form therefore needs no shift register of its own. The code width is a parameter. The DAC, the comparator and the sample-and-hold sit outside this block.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `ser_valid` are 0, and `result` and `dac_code` are all zeros.
- R2: A `start` pulse sampled while idle makes `busy` go high at the next edge. In that first trial cycle, `dac_code` has only its most significant bit set.
- R3: While bit k is under trial, `dac_code` equals the bits already decided above k, plus a 1 at position k, plus zeros at every position below k. Bit positions are tried from WIDTH-1 down to 0, one per cycle.
- R4: At the end of each trial cycle, the trial bit is kept if `cmp_hi` is 1 and cleared if `cmp_hi` is 0. With a comparator that is high when the input is at or above the trial code, the final `result` equals the input code for every value, including all-zeros and all-ones.
- R5: Take the edge that samples `start` as edge s. `done` is high for exactly one cycle, between edges s+WIDTH and s+WIDTH+1, and `result` holds the final code in that cycle. `busy` is high from edge s to edge s+WIDTH+1. The timing does not depend on the input value.
- R6: `result` keeps its value after `done` until the next conversion completes.
- R7: `ser_valid` is high in exactly the WIDTH trial cycles. In each of those cycles `ser_bit` equals the bit being decided, so the bits come out most significant first.
- R8: A `start` pulse while `busy` is high, in a trial cycle or in the done cycle, is ignored. The conversion in progress keeps its timing and its result, and the block returns to idle after the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a conversion (only acted on when idle) |
| cmp_hi | input | 1 | Comparator: 1 when the analog input is above the DAC level |
| dac_code | output | WIDTH | Trial code driven to the DAC |
| busy | output | 1 | Conversion in progress (trial or done cycle) |
| done | output | 1 | One-cycle strobe marking a new result |
| result | output | WIDTH | Parallel result of the last conversion |
| ser_bit | output | 1 | Serial result bit, most significant first |
| ser_valid | output | 1 | Qualifies `ser_bit` in each decision cycle |

## Verification
A corrupted bit-position index shows up on `dac_code` in the same cycle. The trial bit lands in the wrong place, or stale low bits appear beneath it. Once that code is fed to the next comparison, `result` and the serial stream are wrong too. A bad state transition appears as a `done` strobe one or more cycles early or late, or as `busy` staying high after the done cycle. Either fault is visible within WIDTH+2 cycles of the start pulse.

// File: rtl/sar_pkg.sv
package sar_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_TRIAL = 2'd1,
      ST_DONE  = 2'd2
   } sar_state_t;

endpackage

// File: rtl/sar_seq.sv
module sar_seq
   import sar_pkg::*;
#(
   parameter int WIDTH = 8,
   localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output sar_state_t    state_o,
   output logic [IW-1:0] idx_o,
   output logic          load_o,
   output logic          trial_o,
   output logic          last_o
);

   sar_state_t    state_q;
   logic [IW-1:0] idx_q;

   assign load_o  = (state_q == ST_IDLE) && start;
   assign trial_o = (state_q == ST_TRIAL);
   assign last_o  = trial_o && (idx_q == '0);
   assign state_o = state_q;
   assign idx_o   = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_TRIAL;
                  idx_q   <= IW'(WIDTH - 1);
               end
            end
            ST_TRIAL: begin
               if (idx_q == '0) begin
                  state_q <= ST_DONE;
               end else begin
                  idx_q <= idx_q - 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R3
   idx_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trial_o && idx_q != '0) |=> (trial_o && idx_q == IW'($past(idx_q) - 1'b1)));

   // R5
   done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DONE) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sar_bitreg.sv
module sar_bitreg #(
   parameter int WIDTH = 8,
   localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             trial,
   input  logic             last,
   input  logic [IW-1:0]    idx,
   input  logic             cmp_hi,
   output logic [WIDTH-1:0] dac_code,
   output logic [WIDTH-1:0] result
);

   logic [WIDTH-1:0] code_q;
   logic [WIDTH-1:0] code_d;
   logic [WIDTH-1:0] sel;
   logic [WIDTH-1:0] result_q;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign sel[i]      = trial && (idx == IW'(i));
      assign code_d[i]   = load ? 1'b0 : (sel[i] ? cmp_hi : code_q[i]);
      assign dac_code[i] = code_q[i] | sel[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q   <= '0;
         result_q <= '0;
      end else begin
         code_q <= code_d;
         if (last) begin
            result_q <= code_d;
         end
      end
   end

   assign result = result_q;

   // R3
   low_bits_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trial |-> ((dac_code & ((WIDTH'(1) << idx) - WIDTH'(1))) == '0));

endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
   import sar_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cmp_hi,
   output logic [WIDTH-1:0] dac_code,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] result,
   output logic             ser_bit,
   output logic             ser_valid
);

   localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

   if (WIDTH < 2) begin : g_width_bad
      $error("sar_ctrl: WIDTH must be at least 2");
   end

   sar_state_t    state;
   logic [IW-1:0] idx;
   logic          load;
   logic          trial;
   logic          last;

   sar_seq #(.WIDTH(WIDTH)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .state_o (state),
      .idx_o   (idx),
      .load_o  (load),
      .trial_o (trial),
      .last_o  (last)
   );

   sar_bitreg #(.WIDTH(WIDTH)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .trial    (trial),
      .last     (last),
      .idx      (idx),
      .cmp_hi   (cmp_hi),
      .dac_code (dac_code),
      .result   (result)
   );

   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_DONE);
   assign ser_valid = trial;
   assign ser_bit   = trial & cmp_hi;

   // R5
   done_after_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(ser_valid));

   // R4
   result_matches_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ((result | WIDTH'(1)) == ($past(dac_code) | WIDTH'(1))));

   // R7
   serial_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_valid |-> (busy && !done));

   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !$past(ser_valid)) |-> $stable(result));

endmodule

// File: tb/tb_sar_ctrl.sv
`timescale 1ns/1ps
module tb_sar_ctrl;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         cmp_hi;
   logic [W-1:0] dac_code;
   logic         busy, done, ser_bit, ser_valid;
   logic [W-1:0] result;
   logic [W-1:0] target = '0;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   // comparator model: input held at target plus half an LSB
   assign cmp_hi = (target >= dac_code);

   sar_ctrl #(.WIDTH(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmp_hi(cmp_hi),
      .dac_code(dac_code), .busy(busy), .done(done), .result(result),
      .ser_bit(ser_bit), .ser_valid(ser_valid)
   );

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] exp_trial(input logic [W-1:0] t, input int k);
      logic [W-1:0] above;
      above = t & ~((W'(1) << k) - W'(1)) & ~(W'(1) << k);
      return above | (W'(1) << k);
   endfunction

   task automatic convert(input logic [W-1:0] t, input bit poke_busy, input bit poke_done);
      logic [W-1:0] prev;
      prev   = result;
      target = t;
      start  = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int k = W - 1; k >= 0; k--) begin
         if (k == W - 1)
            check(busy && dac_code == (W'(1) << (W - 1)), "R2 first trial",
                  {busy, dac_code}, {1'b1, W'(1) << (W - 1)});
         check(dac_code == exp_trial(t, k), "R3 trial code", dac_code, exp_trial(t, k));
         check(ser_valid && ser_bit == t[k], "R7 serial bit", {ser_valid, ser_bit},
               {1'b1, t[k]});
         check(!done && result == prev, "R6 result held during conversion",
               result, prev);
         if (poke_busy && k == W - 3) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      check(done && busy && !ser_valid, "R5 done cycle", {done, busy, ser_valid}, 3'b110);
      check(result == t, "R4 final result", result, t);
      if (poke_done) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(!done && !busy, "R5 done single cycle", {done, busy}, 2'b00);
      if (poke_busy || poke_done)
         check(!busy && !ser_valid, "R8 start while busy ignored", {busy, ser_valid}, 2'b00);
      @(negedge clk);
      check(result == t && !busy, "R6 result held after done", result, t);
   endtask

   initial begin
      logic [W-1:0] vec;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(!busy && !done && !ser_valid, "R1 reset flags", {busy, done, ser_valid}, 3'b000);
      check(result == '0 && dac_code == '0, "R1 reset codes", {result, dac_code}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      convert('0, 1'b0, 1'b0);
      convert('1, 1'b0, 1'b0);
      convert(W'(1), 1'b0, 1'b0);
      convert(~W'(1), 1'b0, 1'b0);
      convert(W'(1) << (W - 1), 1'b1, 1'b0);
      convert(~(W'(1) << (W - 1)), 1'b0, 1'b1);
      convert(W'('h55), 1'b1, 1'b1);
      convert(W'('hAA), 1'b0, 1'b0);
      for (int i = 0; i < 40; i++) begin
         vec = W'($urandom);
         convert(vec, i[0], i[1]);
         repeat (i % 3) @(negedge clk);
      end
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule